// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits between the host bus of a byte-wide NOR flash device and its internal write state machine. It turns the host's write strobes into commands. Each strobe is synchronised into the internal clock, and the address and data are kept from the last cycle in which the strobe and chip enable were both low. The block then decodes the byte on the strobe's rising edge. It decides what a host read returns: array data, a two-byte identifier, or a status byte. It also issues single-cycle start, suspend and resume requests to the state machine, which runs the erase and program timing itself.

Erase and byte write each need two host writes: a setup cycle followed by a confirming or data cycle. A broken erase sequence is flagged in the status byte, and the decoder refuses to launch an operation while the high-voltage supply is reported absent. What the decoder accepts depends on the state of the write state machine. A running byte write accepts only a status read. A running erase accepts only a status read or a suspend. A suspended erase accepts only a switch to array reads, a switch to status reads, or a resume.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After system reset the read mode is array (rd_mode = 0) and rd_data follows array_q.
- R2: Command 90h selects identifier mode (rd_mode = 1). In this mode address 0 reads 89h, address 1 reads A2h and any other address reads 00h. The mode persists across reads until another accepted command changes it.
- R3: Command 70h selects status mode (rd_mode = 2). The status byte is bit7 = not wsm_busy, bit6 = wsm_susp, bit5 = erase error, bit4 = write error, bit3 = supply error, and bits 2..0 = 0.
- R4: Setup byte 40h or 10h, followed by a second write, gives exactly one write_start pulse. op_addr and op_data carry that second write's address and data, and the read mode becomes status.
- R5: Byte 20h followed by D0h gives exactly one erase_start pulse. erase_block carries address bits 19..16 of the confirm write, and the read mode becomes status.
- R6: Byte 20h followed by anything other than D0h starts nothing, sets both the erase and write error bits, and selects status mode.
- R7: Command 50h clears the erase, write and supply error bits.
- R8: While a byte write runs (wsm_busy high after write_start), every command other than 70h is ignored.
- R9: While an erase runs, FFh is ignored and B0h gives one suspend_req pulse.
- R10: While wsm_susp is high, only FFh (array), 70h (status) and D0h (one resume_req pulse plus status mode) are accepted; 90h is ignored.
- R11: A launch attempted while vpp_ok is low, or while the supply error bit is already set, starts nothing and sets the supply error bit.
- R12: Strobes with ce_n high or rp_n low are ignored. rp_n low forces array mode and clears all error bits.
- R13: Unrecognised bytes (for example 00h, or D0h or B0h while idle) leave the mode unchanged and start nothing.
- R14: At most one of the four request outputs is high in any cycle, and each accepted strobe is decoded exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| rp_n | input | 1 | Device reset / powerdown, active low |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| addr | input | 20 | Host address |
| din | input | 8 | Host write data |
| array_q | input | 8 | Array read data from the storage core |
| vpp_ok | input | 1 | High-voltage supply present |
| wsm_busy | input | 1 | Write state machine running an operation |
| wsm_susp | input | 1 | Erase held in suspension |
| rd_mode | output | 2 | Read mode: 0 array, 1 identifier, 2 status |
| rd_data | output | 8 | Byte returned for a host read |
| erase_start | output | 1 | One-cycle erase launch request |
| write_start | output | 1 | One-cycle byte write launch request |
| suspend_req | output | 1 | One-cycle erase suspend request |
| resume_req | output | 1 | One-cycle erase resume request |
| op_addr | output | 20 | Address of the launched operation |
| op_data | output | 8 | Data of the launched byte write |
| erase_block | output | 4 | Block number of the launched erase |

## Verification
The decode of a command can land in the same internal cycle in which the write state machine drops its busy flag. In that case the busy/idle context must be judged from the value present at the decode edge. The bench provokes this by releasing the strobe and lowering wsm_busy exactly two cycles later, on the cycle the synchroniser reports the rising edge. An FFh written during a byte write is then accepted and moves the read mode to array, while the same FFh one cycle earlier is ignored. A second such overlap is an erase confirm arriving while the supply error is already latched, which the bench expects to be refused.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] OP_IDENT       = 8'h90;
  localparam logic [7:0] OP_READ_STAT   = 8'h70;
  localparam logic [7:0] OP_CLR_STAT    = 8'h50;
  localparam logic [7:0] OP_ERASE_SETUP = 8'h20;
  localparam logic [7:0] OP_CONFIRM     = 8'hD0;
  localparam logic [7:0] OP_SUSPEND     = 8'hB0;
  localparam logic [7:0] OP_WR_SETUP_A  = 8'h40;
  localparam logic [7:0] OP_WR_SETUP_B  = 8'h10;

  localparam logic [7:0] ID_MAKER  = 8'h89;
  localparam logic [7:0] ID_DEVICE = 8'hA2;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_IDENT  = 2'd1,
    RM_STATUS = 2'd2
  } rd_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE         = 2'd0,
    SQ_ERASE_ARMED  = 2'd1,
    SQ_WRITE_ARMED  = 2'd2
  } seq_e;

  function automatic logic [7:0] ident_code(input logic at_zero, input logic at_one);
    if (at_zero)     return ID_MAKER;
    else if (at_one) return ID_DEVICE;
    else             return 8'h00;
  endfunction

  function automatic logic [7:0] status_pack(input logic ready, input logic susp,
                                             input logic e_err, input logic w_err,
                                             input logic v_err);
    return {ready, susp, e_err, w_err, v_err, 3'b000};
  endfunction

  function automatic logic is_write_setup(input logic [7:0] op);
    return (op == OP_WR_SETUP_A) || (op == OP_WR_SETUP_B);
  endfunction
endpackage

// File: rtl/fcd_strobe_sync.sv
module fcd_strobe_sync #(
  parameter int ADDR_W      = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rp_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] we_pipe;
  logic              armed;
  logic              strobe_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_pipe <= '1;
    else        we_pipe <= {we_pipe[PIPE_W-2:0], we_n};
  end

  assign strobe_rise = we_pipe[SYNC_STAGES-1] & ~we_pipe[SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else if (!rp_n) begin
      armed <= 1'b0;
    end else if (!we_n && !ce_n) begin
      armed    <= 1'b1;
      cmd_addr <= addr;
      cmd_data <= din;
    end else if (strobe_rise) begin
      armed <= 1'b0;
    end
  end

  assign cmd_valid = strobe_rise & armed & rp_n;

  p_single_decode_r14: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
endmodule

// File: rtl/fcd_cmd_fsm.sv
module fcd_cmd_fsm
  import fcd_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int BLOCK_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rp_n,
  input  logic               vpp_ok,
  input  logic               wsm_busy,
  input  logic               wsm_susp,
  input  logic               cmd_valid,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [7:0]         cmd_data,
  output rd_mode_e           mode,
  output logic               err_erase,
  output logic               err_write,
  output logic               err_vpp,
  output logic               erase_start,
  output logic               write_start,
  output logic               suspend_req,
  output logic               resume_req,
  output logic [ADDR_W-1:0]  op_addr,
  output logic [7:0]         op_data,
  output logic [BLOCK_W-1:0] erase_block
);
  function automatic logic [BLOCK_W-1:0] block_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: BLOCK_W];
  endfunction

  seq_e seq, n_seq;
  rd_mode_e n_mode;
  logic op_is_write, n_opw;
  logic n_ee, n_ew, n_ev, n_es, n_ws, n_sus, n_res;
  logic [ADDR_W-1:0]  n_oa;
  logic [7:0]         n_od;
  logic [BLOCK_W-1:0] n_blk;

  // context wires, brought out for the assertions
  logic ctx_susp, ctx_busy_wr, ctx_busy_er, ctx_idle, launch_ok;
  assign ctx_susp    = wsm_susp;
  assign ctx_busy_wr = wsm_busy & ~wsm_susp & op_is_write;
  assign ctx_busy_er = wsm_busy & ~wsm_susp & ~op_is_write;
  assign ctx_idle    = ~wsm_busy & ~wsm_susp;
  assign launch_ok   = vpp_ok & ~err_vpp;

  always_comb begin
    n_mode = mode;
    n_seq  = seq;
    n_ee   = err_erase;
    n_ew   = err_write;
    n_ev   = err_vpp;
    n_es   = 1'b0;
    n_ws   = 1'b0;
    n_sus  = 1'b0;
    n_res  = 1'b0;
    n_opw  = op_is_write;
    n_oa   = op_addr;
    n_od   = op_data;
    n_blk  = erase_block;
    if (cmd_valid) begin
      if (ctx_susp) begin
        case (cmd_data)
          OP_READ_ARRAY: n_mode = RM_ARRAY;
          OP_READ_STAT:  n_mode = RM_STATUS;
          OP_CONFIRM: begin
            n_res  = 1'b1;
            n_mode = RM_STATUS;
          end
          default: ;
        endcase
      end else if (ctx_busy_wr) begin
        if (cmd_data == OP_READ_STAT) n_mode = RM_STATUS;
      end else if (ctx_busy_er) begin
        case (cmd_data)
          OP_READ_STAT: n_mode = RM_STATUS;
          OP_SUSPEND: begin
            n_sus  = 1'b1;
            n_mode = RM_STATUS;
          end
          default: ;
        endcase
      end else begin
        case (seq)
          SQ_ERASE_ARMED: begin
            n_seq  = SQ_IDLE;
            n_mode = RM_STATUS;
            if (cmd_data == OP_CONFIRM) begin
              if (launch_ok) begin
                n_es  = 1'b1;
                n_opw = 1'b0;
                n_oa  = cmd_addr;
                n_blk = block_of(cmd_addr);
              end else begin
                n_ev = 1'b1;
              end
            end else begin
              n_ee = 1'b1;
              n_ew = 1'b1;
            end
          end
          SQ_WRITE_ARMED: begin
            n_seq  = SQ_IDLE;
            n_mode = RM_STATUS;
            if (launch_ok) begin
              n_ws  = 1'b1;
              n_opw = 1'b1;
              n_oa  = cmd_addr;
              n_od  = cmd_data;
            end else begin
              n_ev = 1'b1;
            end
          end
          default: begin
            if (is_write_setup(cmd_data)) begin
              n_seq = SQ_WRITE_ARMED;
            end else begin
              case (cmd_data)
                OP_READ_ARRAY:  n_mode = RM_ARRAY;
                OP_IDENT:       n_mode = RM_IDENT;
                OP_READ_STAT:   n_mode = RM_STATUS;
                OP_ERASE_SETUP: n_seq  = SQ_ERASE_ARMED;
                OP_CLR_STAT: begin
                  n_ee = 1'b0;
                  n_ew = 1'b0;
                  n_ev = 1'b0;
                end
                default: ;
              endcase
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode        <= RM_ARRAY;
      seq         <= SQ_IDLE;
      err_erase   <= 1'b0;
      err_write   <= 1'b0;
      err_vpp     <= 1'b0;
      erase_start <= 1'b0;
      write_start <= 1'b0;
      suspend_req <= 1'b0;
      resume_req  <= 1'b0;
      op_is_write <= 1'b0;
      op_addr     <= '0;
      op_data     <= '0;
      erase_block <= '0;
    end else if (!rp_n) begin
      mode        <= RM_ARRAY;
      seq         <= SQ_IDLE;
      err_erase   <= 1'b0;
      err_write   <= 1'b0;
      err_vpp     <= 1'b0;
      erase_start <= 1'b0;
      write_start <= 1'b0;
      suspend_req <= 1'b0;
      resume_req  <= 1'b0;
    end else begin
      mode        <= n_mode;
      seq         <= n_seq;
      err_erase   <= n_ee;
      err_write   <= n_ew;
      err_vpp     <= n_ev;
      erase_start <= n_es;
      write_start <= n_ws;
      suspend_req <= n_sus;
      resume_req  <= n_res;
      op_is_write <= n_opw;
      op_addr     <= n_oa;
      op_data     <= n_od;
      erase_block <= n_blk;
    end
  end

  p_rp_forces_array_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rp_n |=> (mode == RM_ARRAY) && !err_erase && !err_write && !err_vpp);

  p_bad_confirm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && rp_n && ctx_idle && seq == SQ_ERASE_ARMED && cmd_data != OP_CONFIRM)
    |=> err_erase && err_write && !erase_start && (mode == RM_STATUS));

  p_no_supply_launch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && rp_n && ctx_idle && seq == SQ_WRITE_ARMED && !vpp_ok)
    |=> !write_start && err_vpp);

  p_write_busy_filter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && rp_n && ctx_busy_wr && cmd_data != OP_READ_STAT) |=> $stable(mode));

  p_launch_shows_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_start || write_start) |-> (mode == RM_STATUS));

  p_one_request_r14: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_start, write_start, suspend_req, resume_req}));
endmodule

// File: rtl/fcd_read_mux.sv
module fcd_read_mux
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  rd_mode_e          mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        array_q,
  input  logic              wsm_busy,
  input  logic              wsm_susp,
  input  logic              err_erase,
  input  logic              err_write,
  input  logic              err_vpp,
  output logic [7:0]        rd_data
);
  logic at_zero, at_one;
  assign at_zero = (addr == ADDR_W'(0));
  assign at_one  = (addr == ADDR_W'(1));

  always_comb begin
    case (mode)
      RM_ARRAY:  rd_data = array_q;
      RM_IDENT:  rd_data = ident_code(at_zero, at_one);
      RM_STATUS: rd_data = status_pack(~wsm_busy, wsm_susp, err_erase, err_write, err_vpp);
      default:   rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int BLOCK_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rp_n,
  input  logic               ce_n,
  input  logic               we_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [7:0]         din,
  input  logic [7:0]         array_q,
  input  logic               vpp_ok,
  input  logic               wsm_busy,
  input  logic               wsm_susp,
  output logic [1:0]         rd_mode,
  output logic [7:0]         rd_data,
  output logic               erase_start,
  output logic               write_start,
  output logic               suspend_req,
  output logic               resume_req,
  output logic [ADDR_W-1:0]  op_addr,
  output logic [7:0]         op_data,
  output logic [BLOCK_W-1:0] erase_block
);
  logic              cmd_valid;
  logic [ADDR_W-1:0] cmd_addr;
  logic [7:0]        cmd_data;
  rd_mode_e          mode;
  logic              err_erase, err_write, err_vpp;

  fcd_strobe_sync #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .ce_n(ce_n), .we_n(we_n),
    .addr(addr), .din(din),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  fcd_cmd_fsm #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .vpp_ok(vpp_ok),
    .wsm_busy(wsm_busy), .wsm_susp(wsm_susp),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .mode(mode), .err_erase(err_erase), .err_write(err_write), .err_vpp(err_vpp),
    .erase_start(erase_start), .write_start(write_start),
    .suspend_req(suspend_req), .resume_req(resume_req),
    .op_addr(op_addr), .op_data(op_data), .erase_block(erase_block)
  );

  fcd_read_mux #(.ADDR_W(ADDR_W)) u_mux (
    .mode(mode), .addr(addr), .array_q(array_q),
    .wsm_busy(wsm_busy), .wsm_susp(wsm_susp),
    .err_erase(err_erase), .err_write(err_write), .err_vpp(err_vpp),
    .rd_data(rd_data)
  );

  assign rd_mode = mode;
endmodule

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  logic clk = 1'b0;
  logic rst_n, rp_n, ce_n, we_n, vpp_ok, wsm_busy, wsm_susp;
  logic [19:0] addr;
  logic [7:0]  din, array_q;
  logic [1:0]  rd_mode;
  logic [7:0]  rd_data, op_data;
  logic        erase_start, write_start, suspend_req, resume_req;
  logic [19:0] op_addr;
  logic [3:0]  erase_block;

  int n_cmp = 0, n_bad = 0;
  int n_es = 0, n_ws = 0, n_sus = 0, n_res = 0;
  logic [19:0] seen_wa;
  logic [7:0]  seen_wd;
  logic [3:0]  seen_blk;
  bit finished = 0;

  always #2 clk = ~clk;

  flash_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .ce_n(ce_n), .we_n(we_n),
    .addr(addr), .din(din), .array_q(array_q), .vpp_ok(vpp_ok),
    .wsm_busy(wsm_busy), .wsm_susp(wsm_susp),
    .rd_mode(rd_mode), .rd_data(rd_data),
    .erase_start(erase_start), .write_start(write_start),
    .suspend_req(suspend_req), .resume_req(resume_req),
    .op_addr(op_addr), .op_data(op_data), .erase_block(erase_block)
  );

  always @(negedge clk) begin
    if (erase_start) begin n_es++; seen_blk = erase_block; end
    if (write_start) begin n_ws++; seen_wa = op_addr; seen_wd = op_data; end
    if (suspend_req) n_sus++;
    if (resume_req)  n_res++;
  end

  function automatic logic [7:0] exp_status(input logic busy, input logic susp,
                                            input logic ee, input logic ew, input logic ev);
    return {~busy, susp, ee, ew, ev, 3'b000};
  endfunction

  function automatic logic [1:0] exp_mode(input logic [1:0] cur, input logic [7:0] op);
    case (op)
      8'hFF:   return 2'd0;
      8'h90:   return 2'd1;
      8'h70:   return 2'd2;
      default: return cur;
    endcase
  endfunction

  function automatic logic [7:0] exp_ident(input logic [19:0] a);
    if (a == 20'd0) return 8'h89;
    if (a == 20'd1) return 8'hA2;
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [19:0] a, input logic [7:0] d,
                            input bit ce_on = 1'b1, input bit drop_busy = 1'b0);
    @(negedge clk);
    addr = a; din = d; ce_n = ~ce_on; we_n = 1'b0;
    repeat (3) @(negedge clk);
    we_n = 1'b1;
    repeat (2) @(negedge clk);
    if (drop_busy) wsm_busy = 1'b0;
    repeat (2) @(negedge clk);
    ce_n = 1'b1;
  endtask

  task automatic read_at(input logic [19:0] a);
    addr = a;
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [1:0] cur;
    void'($urandom(32'h5EED1));
    rst_n = 0; rp_n = 1; ce_n = 1; we_n = 1; addr = 0; din = 0;
    array_q = 8'h5A; vpp_ok = 1; wsm_busy = 0; wsm_susp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", rd_mode, 2'd0);
    read_at(20'h12345); chk("R1 data", rd_data, 8'h5A);

    // R2 identifier
    host_write(20'h0, 8'h90);
    chk("R2 mode", rd_mode, 2'd1);
    read_at(20'h0); chk("R2 maker", rd_data, 8'h89);
    read_at(20'h1); chk("R2 device", rd_data, 8'hA2);
    read_at(20'h2); chk("R2 other", rd_data, 8'h00);
    read_at(20'h0); chk("R2 persists", rd_data, 8'h89);
    // R13 unrecognised bytes
    host_write(20'h0, 8'h00);
    chk("R13 00h ignored", rd_mode, 2'd1);
    host_write(20'h0, 8'hD0);
    chk("R13 D0h idle ignored", rd_mode, 2'd1);
    chk("R13 no resume", n_res, 0);

    // R3 status
    host_write(20'h0, 8'h70);
    chk("R3 mode", rd_mode, 2'd2);
    chk("R3 byte", rd_data, exp_status(0, 0, 0, 0, 0));

    // R6 improper erase sequence
    host_write(20'h30000, 8'h20);
    host_write(20'h30000, 8'hFF);
    chk("R6 errors", rd_data, exp_status(0, 0, 1, 1, 0));
    chk("R6 no start", n_es, 0);
    chk("R6 mode", rd_mode, 2'd2);
    // R7 clear
    host_write(20'h0, 8'h50);
    chk("R7 cleared", rd_data, exp_status(0, 0, 0, 0, 0));

    // R4 byte write with alternate setup
    host_write(20'h31234, 8'h10);
    host_write(20'h31234, 8'h5C);
    chk("R4 one start", n_ws, 1);
    chk("R4 addr", seen_wa, 20'h31234);
    chk("R4 data", seen_wd, 8'h5C);
    chk("R4 mode", rd_mode, 2'd2);
    wsm_busy = 1;
    // R8 write busy filter
    host_write(20'h0, 8'hFF);
    chk("R8 FFh ignored", rd_mode, 2'd2);
    host_write(20'h0, 8'h90);
    chk("R8 90h ignored", rd_mode, 2'd2);
    chk("R8 busy status", rd_data, exp_status(1, 0, 0, 0, 0));
    // same-cycle case: busy drops at decode edge, FFh accepted
    host_write(20'h0, 8'hFF, 1'b1, 1'b1);
    chk("R8 busy drop same cycle", rd_mode, 2'd0);

    // R5 erase
    host_write(20'hA0000, 8'h20);
    host_write(20'hA7777, 8'hD0);
    chk("R5 one start", n_es, 1);
    chk("R5 block", seen_blk, 4'hA);
    chk("R5 mode", rd_mode, 2'd2);
    wsm_busy = 1;
    // R9 erase busy
    host_write(20'h0, 8'hFF);
    chk("R9 FFh ignored", rd_mode, 2'd2);
    host_write(20'h0, 8'hB0);
    chk("R9 suspend", n_sus, 1);
    wsm_busy = 0; wsm_susp = 1;
    #1 chk("R3 suspended byte", rd_data, exp_status(0, 1, 0, 0, 0));
    // R10 suspended
    host_write(20'h0, 8'h90);
    chk("R10 90h ignored", rd_mode, 2'd2);
    host_write(20'h0, 8'hFF);
    chk("R10 array", rd_mode, 2'd0);
    host_write(20'h0, 8'hD0);
    chk("R10 resume", n_res, 1);
    chk("R10 mode", rd_mode, 2'd2);
    chk("R14 no extra requests", n_es + n_ws + n_sus, 3);
    wsm_susp = 0; wsm_busy = 1;
    repeat (3) @(negedge clk);
    wsm_busy = 0;

    // R11 supply
    vpp_ok = 0;
    host_write(20'h0, 8'h40);
    host_write(20'h00055, 8'h11);
    chk("R11 no write", n_ws, 1);
    chk("R11 vpp bit", rd_data, exp_status(0, 0, 0, 0, 1));
    vpp_ok = 1;
    host_write(20'h50000, 8'h20);
    host_write(20'h50000, 8'hD0);
    chk("R11 latched refuse", n_es, 1);
    host_write(20'h0, 8'h50);
    chk("R7 vpp cleared", rd_data, exp_status(0, 0, 0, 0, 0));

    // R12 ignored strobes and rp_n
    host_write(20'h0, 8'h90, 1'b0);
    chk("R12 ce high ignored", rd_mode, 2'd2);
    host_write(20'h0, 8'h20);
    host_write(20'h0, 8'h00);
    chk("R6 errors again", rd_data, exp_status(0, 0, 1, 1, 0));
    rp_n = 0;
    host_write(20'h0, 8'h90);
    chk("R12 rp low array", rd_mode, 2'd0);
    rp_n = 1;
    @(negedge clk);
    chk("R12 stays array", rd_mode, 2'd0);
    host_write(20'h0, 8'h70);
    chk("R12 errors cleared", rd_data, exp_status(0, 0, 0, 0, 0));

    // constrained random command stream in idle
    cur = 2'd2;
    for (int i = 0; i < 40; i++) begin
      logic [7:0] op;
      logic [19:0] ra;
      case ($urandom % 6)
        0: op = 8'hFF;
        1: op = 8'h90;
        2: op = 8'h70;
        3: op = 8'h50;
        4: op = 8'h00;
        default: op = 8'h33;
      endcase
      host_write(20'($urandom), op);
      cur = exp_mode(cur, op);
      chk("R13 random mode", rd_mode, cur);
      ra = 20'($urandom % 3);
      read_at(ra);
      if (cur == 2'd1)      chk("R2 random ident", rd_data, exp_ident(ra));
      else if (cur == 2'd2) chk("R3 random status", rd_data, exp_status(0, 0, 0, 0, 0));
      else                  chk("R1 random array", rd_data, array_q);
    end
    chk("R14 no stray starts", n_es + n_ws, 2);
    finish_run();
  end
endmodule